// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block sequences the address stream of a serial port's DMA engine. Software loads an index, a modifier and a word count into the parameter registers. With chaining off and the port and DMA enabled, that write starts a single-shot transfer. With chaining on, the parameters are held until a chain pointer is written. If every start condition holds at that moment, the chain begins. The first transfer uses the parameters as written, and the chain pointer names the descriptor of the second transfer.

At the end of each transfer the sequencer reads a four-word descriptor over a synchronous read port and reloads its working registers from it. It continues until a descriptor whose next pointer is zero has been executed. For every word that the serial engine accepts, the block outputs the current index and modifier and then steps the index by the modifier. Clearing the DMA enable at any point abandons the chain.

Top module: `chain_dma_seq`

## Requirements
- R1: After reset the block is idle: busy, chain_done, word_vld and mem_rd_req are all low.
- R2: A parameter write made while idle, with port and DMA enabled, chaining disabled and a nonzero count, starts a single-shot transfer from the written values on the next cycle. No descriptor is read for it, and chain_done pulses when it ends.
- R3: While a transfer runs, each cycle with xfer_req high and a nonzero remaining count is an accepted word. For that word, word_vld is high, word_addr is the current index and word_mod is the modifier. The index then grows by the modifier (modulo 2^WORD_W) and the count drops by one. The transfer ends when the count reaches zero.
- R4: A chain pointer write starts a chain only when all of these hold: the block is idle, the parameter registers were written with a nonzero count since the last start, and port, DMA and chaining are all enabled. Otherwise the pointer is only stored and busy stays low.
- R5: The first transfer of a chain runs from the parameter registers with no descriptor read before its first word. The written chain pointer is the address of the second transfer's descriptor.
- R6: A descriptor is four words at pointer+0 through pointer+3, holding the next chain pointer, the count, the modifier and the index in that order. The block fetches it with four read requests on consecutive cycles at consecutive addresses, and takes each response on the cycle after its request.
- R7: A descriptor whose next pointer is zero is the last one. After its transfer the block returns to idle and chain_done is high for exactly one cycle, on the same cycle that busy falls.
- R8: Chain pointer writes and parameter writes made while busy are ignored, and the running chain proceeds exactly as set up.
- R9: Clearing cfg_dma_en while busy returns the block to idle on the next cycle. No chain_done pulse follows, and no further words or read requests are issued.
- R10: A fetched descriptor with a count of zero produces no words, and the chain moves on to its next pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_port_en | input | 1 | Serial port enabled |
| cfg_dma_en | input | 1 | DMA enabled; low aborts a running chain |
| cfg_chain_en | input | 1 | Chained mode selected |
| prm_wr_en | input | 1 | Write strobe for the parameter registers |
| prm_wr_idx | input | WORD_W | Index (start address) to write |
| prm_wr_mod | input | WORD_W | Modifier (address step) to write |
| prm_wr_cnt | input | CNT_W | Word count to write |
| cp_wr_en | input | 1 | Write strobe for the chain pointer |
| cp_wr_data | input | WORD_W | Chain pointer value |
| xfer_req | input | 1 | Serial engine requests the next word |
| word_vld | output | 1 | A word is accepted this cycle |
| word_addr | output | WORD_W | Address of the current word |
| word_mod | output | WORD_W | Modifier of the current transfer |
| mem_rd_req | output | 1 | Descriptor read request |
| mem_rd_addr | output | WORD_W | Descriptor read address |
| mem_rd_data | input | WORD_W | Read response, valid the cycle after its request |
| busy | output | 1 | A transfer or descriptor fetch is in progress |
| chain_done | output | 1 | One-cycle pulse when a chain or single shot ends normally |

## Verification
Random chains of one to four transfers are run with random indices, signed modifiers and counts, while xfer_req stalls at random. Comparing each accepted word against an address list built from the descriptors separates correct stepping from errors in field order and in fetch timing. Zero-count descriptors check that an empty transfer is skipped and does not end the chain. Directed cases try a chain pointer write under each missing start condition, and show that the stored parameters still run once the conditions are met. Further directed cases inject writes into a running chain, and drop the DMA enable mid-chain to tell a clean abort from a normal finish.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_FETCH = 2'd2
    } seq_state_e;

    localparam int DESC_WORDS = 4;
endpackage

// File: rtl/chain_start_qual.sv
module chain_start_qual (
    input  logic idle,
    input  logic port_en,
    input  logic dma_en,
    input  logic chain_en,
    input  logic prm_ready,
    input  logic prm_wr_en,
    input  logic prm_cnt_nz,
    input  logic cp_wr_en,
    output logic start_single,
    output logic start_chain
);
    logic enabled;

    always_comb begin
        enabled      = idle && port_en && dma_en;
        start_single = enabled && !chain_en && prm_wr_en && prm_cnt_nz;
        start_chain  = enabled && chain_en && cp_wr_en && prm_ready;
    end
endmodule

// File: rtl/chain_addr_gen.sv
module chain_addr_gen #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prm_wr,
    input  logic [WORD_W-1:0] prm_idx,
    input  logic [WORD_W-1:0] prm_mod,
    input  logic [CNT_W-1:0]  prm_cnt,
    input  logic              desc_ld,
    input  logic [WORD_W-1:0] desc_idx,
    input  logic [WORD_W-1:0] desc_mod,
    input  logic [CNT_W-1:0]  desc_cnt,
    input  logic              step,
    output logic [WORD_W-1:0] cur_idx,
    output logic [WORD_W-1:0] cur_mod,
    output logic [CNT_W-1:0]  cur_cnt
);
    typedef struct packed {
        logic [WORD_W-1:0] idx;
        logic [WORD_W-1:0] mdf;
        logic [CNT_W-1:0]  cnt;
    } ag_s;

    ag_s ag_d, ag_q;

    always_comb begin
        ag_d = ag_q;
        if (prm_wr) begin
            ag_d.idx = prm_idx;
            ag_d.mdf = prm_mod;
            ag_d.cnt = prm_cnt;
        end else if (desc_ld) begin
            ag_d.idx = desc_idx;
            ag_d.mdf = desc_mod;
            ag_d.cnt = desc_cnt;
        end else if (step) begin
            ag_d.idx = ag_q.idx + ag_q.mdf;
            ag_d.cnt = ag_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ag_q <= '0;
        else        ag_q <= ag_d;
    end

    assign cur_idx = ag_q.idx;
    assign cur_mod = ag_q.mdf;
    assign cur_cnt = ag_q.cnt;
endmodule

// File: rtl/chain_desc_fetch.sv
module chain_desc_fetch #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    output logic              done,
    output logic [WORD_W-1:0] next_ptr,
    output logic [WORD_W-1:0] cnt_word,
    output logic [WORD_W-1:0] mod_word,
    output logic [WORD_W-1:0] idx_word
);
    import chain_dma_pkg::*;

    localparam int SEQ_W = $clog2(DESC_WORDS + 1);
    localparam logic [SEQ_W-1:0] LAST_SEQ = SEQ_W'(DESC_WORDS);
    localparam logic [SEQ_W-1:0] SEQ_NXT  = SEQ_W'(1);
    localparam logic [SEQ_W-1:0] SEQ_CNT  = SEQ_W'(2);
    localparam logic [SEQ_W-1:0] SEQ_MOD  = SEQ_W'(3);

    typedef struct packed {
        logic              active;
        logic [SEQ_W-1:0]  seq;
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] nxt;
        logic [WORD_W-1:0] cnt;
        logic [WORD_W-1:0] mdf;
    } fetch_s;

    fetch_s ft_d, ft_q;

    // seq counts issued requests; the response to request k is captured at seq k+1
    always_comb begin
        ft_d = ft_q;
        if (abort) begin
            ft_d.active = 1'b0;
        end else if (start) begin
            ft_d.active = 1'b1;
            ft_d.seq    = '0;
            ft_d.base   = base;
        end else if (ft_q.active) begin
            ft_d.seq = ft_q.seq + SEQ_W'(1);
            case (ft_q.seq)
                SEQ_NXT: ft_d.nxt = rd_data;
                SEQ_CNT: ft_d.cnt = rd_data;
                SEQ_MOD: ft_d.mdf = rd_data;
                default: ;
            endcase
            if (ft_q.seq == LAST_SEQ) ft_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ft_q <= '0;
        else        ft_q <= ft_d;
    end

    assign rd_req   = ft_q.active && (ft_q.seq < LAST_SEQ) && !abort;
    assign rd_addr  = ft_q.base + WORD_W'(ft_q.seq);
    assign done     = ft_q.active && (ft_q.seq == LAST_SEQ) && !abort;
    assign next_ptr = ft_q.nxt;
    assign cnt_word = ft_q.cnt;
    assign mod_word = ft_q.mdf;
    assign idx_word = rd_data;
endmodule

// File: rtl/chain_dma_seq.sv
module chain_dma_seq #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_port_en,
    input  logic              cfg_dma_en,
    input  logic              cfg_chain_en,
    input  logic              prm_wr_en,
    input  logic [WORD_W-1:0] prm_wr_idx,
    input  logic [WORD_W-1:0] prm_wr_mod,
    input  logic [CNT_W-1:0]  prm_wr_cnt,
    input  logic              cp_wr_en,
    input  logic [WORD_W-1:0] cp_wr_data,
    input  logic              xfer_req,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_addr,
    output logic [WORD_W-1:0] word_mod,
    output logic              mem_rd_req,
    output logic [WORD_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              busy,
    output logic              chain_done
);
    import chain_dma_pkg::*;

    typedef struct packed {
        seq_state_e        state;
        logic              chain;
        logic [WORD_W-1:0] cp;
        logic              init;
        logic              done;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic              idle;
    logic              prm_wr_ok;
    logic              cp_wr_ok;
    logic              start_single;
    logic              start_chain;
    logic              step;
    logic              xfer_last;
    logic              desc_ld;
    logic              fetch_start;
    logic              fetch_abort;
    logic              fetch_done;
    logic [WORD_W-1:0] f_next;
    logic [WORD_W-1:0] f_cnt;
    logic [WORD_W-1:0] f_mod;
    logic [WORD_W-1:0] f_idx;
    logic [WORD_W-1:0] cur_idx;
    logic [WORD_W-1:0] cur_mod;
    logic [CNT_W-1:0]  cur_cnt;
    logic              chain_mode;

    assign idle       = (ctl_q.state == ST_IDLE);
    assign prm_wr_ok  = prm_wr_en && idle;
    assign cp_wr_ok   = cp_wr_en && idle;
    assign chain_mode = ctl_q.chain;

    chain_start_qual u_qual (
        .idle         (idle),
        .port_en      (cfg_port_en),
        .dma_en       (cfg_dma_en),
        .chain_en     (cfg_chain_en),
        .prm_ready    (ctl_q.init),
        .prm_wr_en    (prm_wr_en),
        .prm_cnt_nz   (prm_wr_cnt != '0),
        .cp_wr_en     (cp_wr_en),
        .start_single (start_single),
        .start_chain  (start_chain)
    );

    assign step      = (ctl_q.state == ST_XFER) && cfg_dma_en && xfer_req && (cur_cnt != '0);
    assign xfer_last = (cur_cnt == '0) || (step && cur_cnt == CNT_W'(1));

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        fetch_start = 1'b0;
        fetch_abort = 1'b0;
        desc_ld     = 1'b0;
        if (prm_wr_ok) ctl_d.init = (prm_wr_cnt != '0);
        if (cp_wr_ok)  ctl_d.cp   = cp_wr_data;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start_single) begin
                    ctl_d.state = ST_XFER;
                    ctl_d.chain = 1'b0;
                    ctl_d.init  = 1'b0;
                end else if (start_chain) begin
                    ctl_d.state = ST_XFER;
                    ctl_d.chain = 1'b1;
                    ctl_d.init  = 1'b0;
                end
            end
            ST_XFER: begin
                if (xfer_last) begin
                    if (ctl_q.chain && ctl_q.cp != '0) begin
                        ctl_d.state = ST_FETCH;
                        fetch_start = 1'b1;
                    end else begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.done  = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                if (fetch_done) begin
                    desc_ld     = 1'b1;
                    ctl_d.cp    = f_next;
                    ctl_d.state = ST_XFER;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        if (!idle && !cfg_dma_en) begin
            ctl_d.state = ST_IDLE;
            ctl_d.done  = 1'b0;
            fetch_abort = 1'b1;
            fetch_start = 1'b0;
            desc_ld     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    chain_desc_fetch #(.WORD_W(WORD_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (fetch_start),
        .abort    (fetch_abort),
        .base     (ctl_q.cp),
        .rd_data  (mem_rd_data),
        .rd_req   (mem_rd_req),
        .rd_addr  (mem_rd_addr),
        .done     (fetch_done),
        .next_ptr (f_next),
        .cnt_word (f_cnt),
        .mod_word (f_mod),
        .idx_word (f_idx)
    );

    chain_addr_gen #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .prm_wr   (prm_wr_ok),
        .prm_idx  (prm_wr_idx),
        .prm_mod  (prm_wr_mod),
        .prm_cnt  (prm_wr_cnt),
        .desc_ld  (desc_ld),
        .desc_idx (f_idx),
        .desc_mod (f_mod),
        .desc_cnt (f_cnt[CNT_W-1:0]),
        .step     (step),
        .cur_idx  (cur_idx),
        .cur_mod  (cur_mod),
        .cur_cnt  (cur_cnt)
    );

    assign word_vld   = step;
    assign word_addr  = cur_idx;
    assign word_mod   = cur_mod;
    assign busy       = !idle;
    assign chain_done = ctl_q.done;
endmodule

// File: rtl/chain_dma_seq_chk.sv
module chain_dma_seq_chk #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_dma_en,
    input logic              busy,
    input logic              chain_done,
    input logic              word_vld,
    input logic [WORD_W-1:0] word_addr,
    input logic [WORD_W-1:0] word_mod,
    input logic              mem_rd_req,
    input logic [WORD_W-1:0] mem_rd_addr,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic              chain_mode
);
    logic [2:0] req_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          req_run <= '0;
        else if (!mem_rd_req) req_run <= '0;
        else if (req_run != 3'd7) req_run <= req_run + 3'd1;
    end

    // R1: idle outputs quiet
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!word_vld && !mem_rd_req));

    // R2: single shot never reads descriptors
    a_r2_single_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !chain_mode) |-> !mem_rd_req);

    // R3: index steps by the modifier
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && cur_cnt > CNT_W'(1)) |=> word_addr == $past(word_addr) + $past(word_mod));

    // R4: nothing starts with DMA disabled
    a_r4_no_start_dma_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_dma_en) |=> !busy);

    // R6: consecutive requests walk consecutive addresses
    a_r6_addr_consec: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && $past(mem_rd_req)) |-> mem_rd_addr == $past(mem_rd_addr) + WORD_W'(1));

    // R6: at most four requests back to back
    a_r6_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> req_run < 3'd4);

    // R7: done is a single pulse while idle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> (!busy ##1 !chain_done));

    // R9: abort returns to idle
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_dma_en) |=> (!busy && !chain_done));
endmodule

bind chain_dma_seq chain_dma_seq_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_dma_en  (cfg_dma_en),
    .busy        (busy),
    .chain_done  (chain_done),
    .word_vld    (word_vld),
    .word_addr   (word_addr),
    .word_mod    (word_mod),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .cur_cnt     (cur_cnt),
    .chain_mode  (chain_mode)
);

// File: tb/chain_dma_seq_bench.sv
`timescale 1ns/1ps
module chain_dma_seq_bench;
    localparam int WORD_W = 16;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_port_en = 1'b1, cfg_dma_en = 1'b1, cfg_chain_en = 1'b0;
    logic              prm_wr_en = 1'b0;
    logic [WORD_W-1:0] prm_wr_idx = '0, prm_wr_mod = '0;
    logic [CNT_W-1:0]  prm_wr_cnt = '0;
    logic              cp_wr_en = 1'b0;
    logic [WORD_W-1:0] cp_wr_data = '0;
    logic              xfer_req = 1'b0;
    logic              word_vld, mem_rd_req, busy, chain_done;
    logic [WORD_W-1:0] word_addr, word_mod, mem_rd_addr;
    logic [WORD_W-1:0] mem_rd_data = '0;

    logic [WORD_W-1:0] mem [0:255];
    logic [WORD_W-1:0] exp_addr [0:255];
    logic [WORD_W-1:0] exp_mod  [0:255];
    int exp_n, exp_fetch;
    int n_chk = 0, n_err = 0;
    logic [WORD_W-1:0] tr_idx [0:7], tr_mod [0:7], tr_ptr [0:7];
    int tr_cnt [0:7];

    always #2 clk = ~clk;

    always @(posedge clk) if (mem_rd_req) mem_rd_data <= mem[mem_rd_addr[7:0]];

    chain_dma_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chain_dma_seq (
        .clk(clk), .rst_n(rst_n), .cfg_port_en(cfg_port_en), .cfg_dma_en(cfg_dma_en),
        .cfg_chain_en(cfg_chain_en), .prm_wr_en(prm_wr_en), .prm_wr_idx(prm_wr_idx),
        .prm_wr_mod(prm_wr_mod), .prm_wr_cnt(prm_wr_cnt), .cp_wr_en(cp_wr_en),
        .cp_wr_data(cp_wr_data), .xfer_req(xfer_req), .word_vld(word_vld),
        .word_addr(word_addr), .word_mod(word_mod), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .busy(busy),
        .chain_done(chain_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [WORD_W-1:0] step_addr(input logic [WORD_W-1:0] base,
                                                    input logic [WORD_W-1:0] mdf, input int k);
        return base + WORD_W'(k) * mdf;
    endfunction

    // Builds ntr transfers; transfer 0 comes from params, others from descriptors
    task automatic build_chain(input int ntr, input bit allow_zero);
        exp_n = 0;
        exp_fetch = ntr - 1;
        for (int i = 0; i < ntr; i++) begin
            tr_idx[i] = WORD_W'($urandom);
            tr_mod[i] = WORD_W'(int'($urandom % 7) - 3);
            tr_cnt[i] = (i == 0 || !allow_zero) ? 1 + int'($urandom % 5) : int'($urandom % 5);
            tr_ptr[i] = WORD_W'(16 * i);
        end
        for (int i = 1; i < ntr; i++) begin
            mem[16*i]     = (i + 1 < ntr) ? tr_ptr[i+1] : '0;
            mem[16*i + 1] = WORD_W'(tr_cnt[i]);
            mem[16*i + 2] = tr_mod[i];
            mem[16*i + 3] = tr_idx[i];
        end
        for (int i = 0; i < ntr; i++)
            for (int k = 0; k < tr_cnt[i]; k++) begin
                exp_addr[exp_n] = step_addr(tr_idx[i], tr_mod[i], k);
                exp_mod[exp_n]  = tr_mod[i];
                exp_n++;
            end
    endtask

    task automatic write_params(input logic [WORD_W-1:0] idx, input logic [WORD_W-1:0] mdf,
                                input int cnt);
        @(negedge clk);
        prm_wr_en = 1'b1; prm_wr_idx = idx; prm_wr_mod = mdf; prm_wr_cnt = CNT_W'(cnt);
    endtask

    task automatic write_cp(input logic [WORD_W-1:0] ptr);
        @(negedge clk);
        prm_wr_en = 1'b0; cp_wr_en = 1'b1; cp_wr_data = ptr;
    endtask

    // Runs from the cycle after the start edge until busy falls
    task automatic run_seq(input string req, input bit inject, input bit is_chain);
        int k = 0, reads = 0, dones = 0;
        for (int cyc = 0; cyc < 600; cyc++) begin
            @(negedge clk);
            xfer_req = ($urandom % 3) != 0;
            if (inject && cyc == 3) begin
                cp_wr_en = 1'b1; cp_wr_data = 16'h00F0;
                prm_wr_en = 1'b1; prm_wr_idx = 16'hDEAD; prm_wr_cnt = 9;
            end else begin
                cp_wr_en = 1'b0; prm_wr_en = 1'b0;
            end
            #1;
            if (cyc == 0) check(busy, "R5 busy after start", busy, 1);
            if (word_vld) begin
                check(k < exp_n && word_addr == exp_addr[k] && word_mod == exp_mod[k], req,
                      word_addr, (k < exp_n) ? exp_addr[k] : 0);
                if (k == 0 && is_chain) check(reads == 0, "R5 no fetch before first word", reads, 0);
                k++;
            end
            if (mem_rd_req) reads++;
            if (chain_done) dones++;
            if (!busy) break;
        end
        xfer_req = 1'b0; cp_wr_en = 1'b0; prm_wr_en = 1'b0;
        check(k == exp_n, {req, " word count"}, k, exp_n);
        check(reads == 4 * exp_fetch, "R6 read requests", reads, 4 * exp_fetch);
        check(dones == 1, "R7 chain_done pulses", dones, 1);
        @(negedge clk); #1;
        check(!chain_done && !busy, "R7 done one cycle", chain_done, 0);
    endtask

    task automatic run_chain(input int ntr, input bit inject, input bit allow_zero);
        build_chain(ntr, allow_zero);
        @(negedge clk); cfg_chain_en = 1'b1;
        write_params(tr_idx[0], tr_mod[0], tr_cnt[0]);
        write_cp((ntr > 1) ? tr_ptr[1] : '0);
        run_seq(inject ? "R8 chain with injected writes" : "R3 R10 chain words", inject, 1'b1);
    endtask

    task automatic run_single();
        build_chain(1, 1'b0);
        @(negedge clk); cfg_chain_en = 1'b0;
        write_params(tr_idx[0], tr_mod[0], tr_cnt[0]);
        run_seq("R2 single-shot words", 1'b0, 1'b0);
    endtask

    task automatic try_cp(input string req);
        write_cp(16'h0010);
        @(negedge clk); cp_wr_en = 1'b0; #1;
        check(!busy, req, busy, 0);
        @(negedge clk); #1;
        check(!busy && !word_vld, req, busy, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !chain_done && !word_vld && !mem_rd_req, "R1 reset state", busy, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!busy && !chain_done && !mem_rd_req, "R1 after reset", busy, 0);

        // directed single shot, then directed chain with a zero-count middle descriptor
        run_single();
        build_chain(3, 1'b0);
        tr_cnt[1] = 0; mem[17] = '0;
        exp_n = 0;
        for (int i = 0; i < 3; i++)
            for (int k = 0; k < tr_cnt[i]; k++) begin
                exp_addr[exp_n] = step_addr(tr_idx[i], tr_mod[i], k);
                exp_mod[exp_n] = tr_mod[i]; exp_n++;
            end
        @(negedge clk); cfg_chain_en = 1'b1;
        write_params(tr_idx[0], tr_mod[0], tr_cnt[0]);
        write_cp(tr_ptr[1]);
        run_seq("R10 zero-count descriptor skipped", 1'b0, 1'b1);

        // start qualification: params consumed by previous start
        cfg_chain_en = 1'b1;
        try_cp("R4 no start without fresh params");
        @(negedge clk); cfg_dma_en = 1'b0;
        write_params(16'h0200, 16'h0004, 3);
        try_cp("R4 no start with DMA off");
        @(negedge clk); cfg_dma_en = 1'b1; cfg_port_en = 1'b0;
        try_cp("R4 no start with port off");
        @(negedge clk); cfg_port_en = 1'b1; cfg_chain_en = 1'b0;
        try_cp("R4 no start with chaining off");
        @(negedge clk); cfg_chain_en = 1'b1;
        exp_n = 3; exp_fetch = 0;
        for (int k = 0; k < 3; k++) begin
            exp_addr[k] = 16'h0200 + 16'(4 * k); exp_mod[k] = 16'h0004;
        end
        write_cp('0);
        run_seq("R4 stored params used once qualified", 1'b0, 1'b1);

        // writes during an active chain
        run_chain(3, 1'b1, 1'b0);

        // abort mid-chain
        build_chain(3, 1'b0);
        @(negedge clk); cfg_chain_en = 1'b1;
        write_params(tr_idx[0], tr_mod[0], tr_cnt[0]);
        write_cp(tr_ptr[1]);
        @(negedge clk); cp_wr_en = 1'b0; xfer_req = 1'b1;
        @(negedge clk); cfg_dma_en = 1'b0; #1;
        check(busy, "R9 busy before abort edge", busy, 1);
        begin
            int bad = 0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk); #1;
                if (busy || chain_done || word_vld || mem_rd_req) bad++;
            end
            check(bad == 0, "R9 idle after abort", bad, 0);
        end
        xfer_req = 1'b0;
        @(negedge clk); cfg_dma_en = 1'b1;

        // random chains and single shots
        for (int r = 0; r < 14; r++) begin
            if (r % 4 == 3) run_single();
            else run_chain(1 + int'($urandom % 4), r % 5 == 2, 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule